// File: doc/BRIEF.md
# Selectable-Source Up-Counter with Capture

This block is a 16-bit up-counter driven by an 8-bit control register. The register chooses where count ticks come from: every peripheral clock, every second peripheral clock, a tick from a companion timer, or the rising edge of a generic event input. The same register enables the counter and lets it keep running while a standby indication is high. It can also clear the counter whenever the companion timer restarts or overflows, which keeps the two timers in step.

A capture event copies the running count into a capture register. When the counter forms the upper half of a 32-bit pair, the low instance's one-cycle overflow pulse serves as the event input of the high instance. The cascade bit then delays the capture event by one clock, so that a capture sees the carry that has just been added.

Top module: `tick_timer`

## Requirements
- R1: The control register is 8 bits and resets to 0x00. Its fields are: bit 0 enable, bits 3:1 tick source code, bit 4 companion-synchronised restart, bit 5 cascade, bit 6 run during standby. Bit 7 is not stored and always reads 0. A write takes effect on the next clock edge.
- R2: With source code 0, the count rises by one on every clock.
- R3: With source code 1, the count rises by one on every second clock.
- R4: With source code 2, the count rises by one on each clock where `comp_tick_i` is high.
- R5: With source code 7, the count rises by one on each clock where `evt_i` is high and was low at the previous clock.
- R6: Source codes 3, 4, 5 and 6 produce no count ticks.
- R7: While enable and bit 4 are both 1, a high `comp_restart_i` or `comp_ovf_i` clears the count to 0 at the next edge. The clear takes priority over a tick in the same cycle and returns the divide-by-two phase to its start, so that under source code 1 the next increment comes two clocks after the clear. While bit 4 is 0, both inputs are ignored.
- R8: While `standby_i` is high and bit 6 is 0, the count holds. While bit 6 is 1, counting continues during standby.
- R9: While enable is 0, neither the count nor the capture register changes.
- R10: The count wraps from 0xFFFF to 0. `ovf_o` is high for exactly one cycle, namely the cycle in which the count first reads 0 after the wrap.
- R11: With cascade at 0, a capture event seen at a clock edge loads `capture_o` with the count held before that edge. An increment at the same edge does not affect the captured value.
- R12: With cascade at 1, the capture event takes effect one clock later, so `capture_o` receives the count as it stands one cycle after the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| standby_i | input | 1 | Standby sleep indication |
| comp_tick_i | input | 1 | Companion timer count tick |
| comp_restart_i | input | 1 | Companion timer restart |
| comp_ovf_i | input | 1 | Companion timer overflow |
| evt_i | input | 1 | Generic event input (edge-counted) |
| cap_evt_i | input | 1 | Capture event |
| count_o | output | 16 | Current count |
| capture_o | output | 16 | Last captured count |
| ovf_o | output | 1 | One-cycle wrap pulse |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a capture and an increment: the bench raises the capture event while the counter runs every cycle, then expects the value held before the edge in `capture_o` and that value plus one in `count_o`. The second pair is a synchronised restart and a tick: the bench pulses the companion restart under source code 0 and expects 0 rather than 1. It then repeats the restart under source code 1 and expects the count to stay at 0 for two cycles before it reaches 1.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   localparam int CTRL_W = 8;
   localparam int SRC_W  = 3;

   localparam logic [SRC_W-1:0] SRC_PCLK = 3'd0;
   localparam logic [SRC_W-1:0] SRC_HALF = 3'd1;
   localparam logic [SRC_W-1:0] SRC_COMP = 3'd2;
   localparam logic [SRC_W-1:0] SRC_EVT  = 3'd7;

   typedef struct packed {
      logic             spare;
      logic             run_stby;
      logic             cascade;
      logic             sync_rst;
      logic [SRC_W-1:0] src;
      logic             enable;
   } ctrl_t;

endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
   import tick_timer_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CTRL_W-1:0] wdata,
   output ctrl_t             ctrl,
   output logic [CTRL_W-1:0] rdata
);

   localparam logic [CTRL_W-1:0] KEEP_MASK = {1'b0, {(CTRL_W-1){1'b1}}};

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctrl <= '0;
      else if (we)
         ctrl <= ctrl_t'(wdata & KEEP_MASK);
   end

   assign rdata = ctrl;

endmodule

// File: rtl/tick_timer_src.sv
module tick_timer_src
   import tick_timer_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  ctrl_t ctrl,
   input  logic  standby,
   input  logic  comp_tick,
   input  logic  evt,
   input  logic  restart,
   output logic  tick
);

   logic active;
   logic evt_q;
   logic evt_rise;
   logic half_ph;
   logic raw_tick;

   assign active   = ctrl.enable & (~standby | ctrl.run_stby);
   assign evt_rise = evt & ~evt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         evt_q <= 1'b0;
      else
         evt_q <= evt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || restart)
         half_ph <= 1'b0;
      else if (active && ctrl.src == SRC_HALF)
         half_ph <= ~half_ph;
   end

   always_comb begin
      case (ctrl.src)
         SRC_PCLK: raw_tick = 1'b1;
         SRC_HALF: raw_tick = half_ph;
         SRC_COMP: raw_tick = comp_tick;
         SRC_EVT:  raw_tick = evt_rise;
         default:  raw_tick = 1'b0;
      endcase
   end

   assign tick = active & raw_tick;

endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core #(
   parameter int CNT_W       = 16,
   parameter bit HAS_CASCADE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             cascade,
   input  logic             tick,
   input  logic             restart,
   input  logic             cap_evt,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] capture,
   output logic             ovf
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic cap_fire;

   generate
      if (HAS_CASCADE) begin : g_cap_dly
         logic cap_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cap_q <= 1'b0;
            else
               cap_q <= cap_evt;
         end
         assign cap_fire = cascade ? cap_q : cap_evt;
      end else begin : g_cap_direct
         logic unused_cascade;
         assign unused_cascade = cascade;
         assign cap_fire       = cap_evt;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || restart)
         count <= '0;
      else if (tick)
         count <= count + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ovf <= 1'b0;
      else
         ovf <= tick & ~restart & (count == CNT_MAX);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         capture <= '0;
      else if (enable && cap_fire)
         capture <= count;
   end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter bit HAS_CASCADE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   input  logic             standby_i,
   input  logic             comp_tick_i,
   input  logic             comp_restart_i,
   input  logic             comp_ovf_i,
   input  logic             evt_i,
   input  logic             cap_evt_i,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] capture_o,
   output logic             ovf_o
);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("tick_timer: CNT_W must be at least 2");
      end
      if (CTRL_W != 8) begin : g_bad_ctrl
         $error("tick_timer: control register must be 8 bits");
      end
   endgenerate

   ctrl_t ctrl;
   logic  tick;
   logic  restart;

   assign restart = ctrl.enable & ctrl.sync_rst & (comp_restart_i | comp_ovf_i);

   tick_timer_regs i_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we),
      .wdata (reg_wdata),
      .ctrl  (ctrl),
      .rdata (reg_rdata)
   );

   tick_timer_src i_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl      (ctrl),
      .standby   (standby_i),
      .comp_tick (comp_tick_i),
      .evt       (evt_i),
      .restart   (restart),
      .tick      (tick)
   );

   tick_timer_core #(
      .CNT_W       (CNT_W),
      .HAS_CASCADE (HAS_CASCADE)
   ) i_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (ctrl.enable),
      .cascade (ctrl.cascade),
      .tick    (tick),
      .restart (restart),
      .cap_evt (cap_evt_i),
      .count   (count_o),
      .capture (capture_o),
      .ovf     (ovf_o)
   );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [7:0]       reg_rdata,
   input logic             standby_i,
   input logic             comp_restart_i,
   input logic             comp_ovf_i,
   input logic [CNT_W-1:0] count_o,
   input logic [CNT_W-1:0] capture_o,
   input logic             ovf_o
);

   logic       en;
   logic       awake;
   logic       rst_hit;
   logic [2:0] src;

   assign en      = reg_rdata[0];
   assign src     = reg_rdata[3:1];
   assign awake   = ~standby_i | reg_rdata[6];
   assign rst_hit = en & reg_rdata[4] & (comp_restart_i | comp_ovf_i);

   p_spare_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[7] == 1'b0);

   p_every_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en && src == 3'd0 && awake && !rst_hit
      |=> count_o == CNT_W'($past(count_o) + 1'b1));

   p_reserved_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      en && src >= 3'd3 && src <= 3'd6 && !rst_hit |=> $stable(count_o));

   p_restart_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_hit |=> count_o == '0);

   p_standby_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      en && !awake && !rst_hit |=> $stable(count_o));

   p_disabled_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(count_o) && $stable(capture_o));

   p_ovf_at_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> count_o == '0);

   p_ovf_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> !ovf_o);

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) i_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .reg_rdata      (reg_rdata),
   .standby_i      (standby_i),
   .comp_restart_i (comp_restart_i),
   .comp_ovf_i     (comp_ovf_i),
   .count_o        (count_o),
   .capture_o      (capture_o),
   .ovf_o          (ovf_o)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_we = 1'b0;
   logic [7:0]   reg_wdata = '0;
   logic [7:0]   reg_rdata;
   logic         standby_i = 1'b0;
   logic         comp_tick_i = 1'b0;
   logic         comp_restart_i = 1'b0;
   logic         comp_ovf_i = 1'b0;
   logic         evt_i = 1'b0;
   logic         cap_evt_i = 1'b0;
   logic [W-1:0] count_o;
   logic [W-1:0] capture_o;
   logic         ovf_o;

   int errs = 0;
   int checks = 0;

   always #4 clk = ~clk;

   tick_timer i_tick_timer (
      .clk            (clk),
      .rst_n          (rst_n),
      .reg_we         (reg_we),
      .reg_wdata      (reg_wdata),
      .reg_rdata      (reg_rdata),
      .standby_i      (standby_i),
      .comp_tick_i    (comp_tick_i),
      .comp_restart_i (comp_restart_i),
      .comp_ovf_i     (comp_ovf_i),
      .evt_i          (evt_i),
      .cap_evt_i      (cap_evt_i),
      .count_o        (count_o),
      .capture_o      (capture_o),
      .ovf_o          (ovf_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] v);
      reg_we    = 1'b1;
      reg_wdata = v;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic pulse_restart();
      comp_restart_i = 1'b1;
      @(negedge clk);
      comp_restart_i = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [W-1:0] c0;
      logic [W-1:0] cp;
      logic [31:0]  pat;
      logic         prev;
      int           expn;

      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      chk("R1 reset rdata", reg_rdata, 0);
      chk("R1 reset count", count_o, 0);
      chk("R1 reset capture", capture_o, 0);
      chk("R1 reset ovf", ovf_o, 0);

      // R1 bit 7 not stored
      wr(8'hFF);
      chk("R1 readback spare bit", reg_rdata, 8'h7F);
      wr(8'h00);
      chk("R1 readback zero", reg_rdata, 8'h00);

      // R9 disabled: no count, no capture
      c0 = count_o;
      cyc(10);
      chk("R9 hold when disabled", count_o, c0);
      cap_evt_i = 1'b1;
      cyc(1);
      cap_evt_i = 1'b0;
      cyc(2);
      chk("R9 no capture when disabled", capture_o, 0);

      // R2 every clock
      wr(8'h01);
      c0 = count_o;
      cyc(25);
      chk("R2 every clock", count_o, W'(c0 + 25));

      // R3 every second clock
      wr(8'h03);
      c0 = count_o;
      cyc(20);
      chk("R3 half rate", count_o, W'(c0 + 10));

      // R4 companion tick
      wr(8'h05);
      c0 = count_o;
      for (int i = 0; i < 30; i++) begin
         comp_tick_i = (i % 3 == 0);
         @(negedge clk);
      end
      comp_tick_i = 1'b0;
      chk("R4 companion ticks", count_o, W'(c0 + 10));

      // R5 event rising edges
      wr(8'h0F);
      c0   = count_o;
      pat  = 32'hB3C5_0F69;
      prev = 1'b0;
      expn = 0;
      for (int i = 0; i < 32; i++) begin
         if (pat[i] && !prev) expn++;
         prev  = pat[i];
         evt_i = pat[i];
         @(negedge clk);
      end
      evt_i = 1'b0;
      cyc(1);
      chk("R5 event edges", count_o, W'(c0 + expn));

      // R6 reserved codes
      for (int code = 3; code <= 6; code++) begin
         wr({4'b0000, 3'(code), 1'b1});
         c0 = count_o;
         comp_tick_i = 1'b1;
         for (int i = 0; i < 10; i++) begin
            evt_i = i[0];
            @(negedge clk);
         end
         comp_tick_i = 1'b0;
         evt_i = 1'b0;
         chk("R6 reserved code idle", count_o, c0);
      end

      // R8 standby
      wr(8'h01);
      standby_i = 1'b1;
      cyc(1);
      c0 = count_o;
      cyc(10);
      chk("R8 hold in standby", count_o, c0);
      wr(8'h41);
      c0 = count_o;
      cyc(10);
      chk("R8 run in standby", count_o, W'(c0 + 10));
      standby_i = 1'b0;

      // R7 restart ignored while bit 4 is 0
      wr(8'h01);
      c0 = count_o;
      pulse_restart();
      chk("R7 restart ignored", count_o, W'(c0 + 1));
      // R7 restart wins over tick
      wr(8'h11);
      pulse_restart();
      chk("R7 restart clears", count_o, 0);
      cyc(1);
      chk("R7 counts after clear", count_o, 1);
      comp_ovf_i = 1'b1;
      @(negedge clk);
      comp_ovf_i = 1'b0;
      chk("R7 companion overflow clears", count_o, 0);
      // R7 divide phase reset
      wr(8'h13);
      pulse_restart();
      chk("R7 phase clear", count_o, 0);
      cyc(1);
      chk("R7 phase first clock", count_o, 0);
      cyc(1);
      chk("R7 phase second clock", count_o, 1);
      cyc(2);
      chk("R7 phase next", count_o, 2);

      // R11 capture with increment in the same cycle
      wr(8'h01);
      c0 = count_o;
      cap_evt_i = 1'b1;
      @(negedge clk);
      cap_evt_i = 1'b0;
      chk("R11 capture pre-increment", capture_o, c0);
      chk("R11 count advanced", count_o, W'(c0 + 1));

      // R12 cascade delay
      wr(8'h21);
      cp = capture_o;
      c0 = count_o;
      cap_evt_i = 1'b1;
      @(negedge clk);
      cap_evt_i = 1'b0;
      chk("R12 capture not yet", capture_o, cp);
      @(negedge clk);
      chk("R12 capture delayed", capture_o, W'(c0 + 1));

      // R10 full wrap
      wr(8'h11);
      pulse_restart();
      chk("R10 start at zero", count_o, 0);
      cyc(65535);
      chk("R10 top value", count_o, 16'hFFFF);
      chk("R10 no ovf before wrap", ovf_o, 0);
      cyc(1);
      chk("R10 wrap to zero", count_o, 0);
      chk("R10 ovf pulse", ovf_o, 1);
      cyc(1);
      chk("R10 ovf single", ovf_o, 0);
      chk("R10 after wrap", count_o, 1);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule